// File: doc/BRIEF.md
# Fixed-Point Four-Tap FIR Filter

A streaming four-tap finite impulse response filter built only from integer arithmetic. A 16-bit two's-complement sample arrives together with a valid strobe. It is combined with the three samples that came before it, which are held in a delay line. Each tap is multiplied by a fixed constant coefficient, and each product is cut back to 16 bits. The four products are then summed in a two-level tree.

The datapath never grows wider than 16 bits. To make that safe, every adder operand is first shifted right by one bit, sign preserved, so that the carry always has a free bit. The binary-point position is fixed at design time at every node. The real value of the result is the output word divided by 4096.

The filter sits in a sampled signal chain. It produces exactly one output strobe for each input strobe, two clock cycles later.

Top module: `fir4_fixed`

## Requirements
- R1: `in_data` is read as format 1/0/15 (value = word / 32768). The taps x[n], x[n-1], x[n-2] and x[n-3] use the Q15 coefficients 4915, 1638, 14746 and 11469, in that order. Here x[n] is the sample that arrives with the current strobe.
- R2: Each tap product is the full 32-bit signed product, truncated to its upper 16 bits (bits 31..16). This is an arithmetic right shift by 16 with no rounding, and it gives format 1/1/14.
- R3: Products of taps 0 and 1 form one pair, and products of taps 2 and 3 form the other. Each pair sum is (a >>> 1) + (b >>> 1) in format 1/2/13.
- R4: `out_data` = (pair01 >>> 1) + (pair23 >>> 1), in format 1/3/12, and it matches that formula bit for bit.
- R5: For any inputs, including the most negative sample -32768, `out_data`/4096 differs from the exact real filter (0.15, 0.05, 0.45, 0.35) by less than 2^-10. The output stays within [-4104, 4096].
- R6: `out_valid` is high exactly two clock cycles after each cycle in which `in_valid` was high, and it is low otherwise.
- R7: The delay line advances only on cycles with `in_valid` high. Idle cycles between samples do not change the result.
- R8: `out_data` holds its last value while `out_valid` is low.
- R9: A synchronous reset (`rst` high at a clock edge) clears the delay line and the pipeline. After the reset, `out_valid` is 0 and `out_data` is 0, and the first new outputs are computed with zero history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 16 | Sample, format 1/0/15 |
| out_valid | output | 1 | Result strobe |
| out_data | output | 16 | Result, format 1/3/12 |

## Verification
A new sample is multiplied in the same cycle that the delay line shifts. That cycle usually also carries the previous result through the adder tree. Back-to-back strobes, randomly gapped strobes and long idle runs are therefore mixed, and every output is compared bit for bit against an arithmetic model of the truncation and shift chain. Each output is also compared against a real-valued reference within the 2^-10 bound. A reset applied in the middle of a stream is judged by the first outputs after it: they must reflect zero history.

// File: rtl/fir4_fixed.sv
module fir4_fixed #(
  parameter int W  = 16,
  parameter int CW = 16,
  parameter int C0 = 4915,
  parameter int C1 = 1638,
  parameter int C2 = 14746,
  parameter int C3 = 11469
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int NT = 4;
  localparam int PW = W + CW;
  localparam logic signed [CW-1:0] COEF [NT] = '{CW'(C0), CW'(C1), CW'(C2), CW'(C3)};

  logic signed [W-1:0] tap  [NT];
  logic signed [W-1:0] dly  [1:NT-1];
  logic signed [W-1:0] prod [NT];
  logic                v1;

  assign tap[0] = $signed(in_data);

  always_ff @(posedge clk) begin
    if (rst) dly[1] <= '0;
    else if (in_valid) dly[1] <= $signed(in_data);
  end

  for (genvar g = 2; g < NT; g++) begin : g_dly
    always_ff @(posedge clk) begin
      if (rst) dly[g] <= '0;
      else if (in_valid) dly[g] <= dly[g-1];
    end
  end

  for (genvar g = 1; g < NT; g++) begin : g_tap
    assign tap[g] = dly[g];
  end

  for (genvar g = 0; g < NT; g++) begin : g_mul
    logic signed [PW-1:0] full;
    assign full = tap[g] * COEF[g];
    always_ff @(posedge clk) begin
      if (rst) prod[g] <= '0;
      else if (in_valid) prod[g] <= full[PW-1 -: W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else v1 <= in_valid;
  end

  logic signed [W-1:0] s01, s23, sum;
  assign s01 = (prod[0] >>> 1) + (prod[1] >>> 1);
  assign s23 = (prod[2] >>> 1) + (prod[3] >>> 1);
  assign sum = (s01 >>> 1) + (s23 >>> 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= v1;
      if (v1) out_data <= sum;
    end
  end
endmodule

// File: rtl/fir4_fixed_chk.sv
module fir4_fixed_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] in_data,
  input logic         out_valid,
  input logic [W-1:0] out_data
);
  logic [1:0] cnt = '0;
  logic       rst_q = 1'b0;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) cnt <= '0;
    else if (cnt != 2'd3) cnt <= cnt + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst_q) AST_RESET_CLEAR: assert (!out_valid && out_data == '0); // R9
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (cnt >= 2'd2) |-> (out_valid == $past(in_valid, 2))); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cnt >= 2'd1 && !out_valid) |-> $stable(out_data)); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($signed(out_data) >= -4104 && $signed(out_data) <= 4096)); // R5

  wire unused_ok = ^in_data;
endmodule

bind fir4_fixed fir4_fixed_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/fir4_fixed_test.sv
`timescale 1ns/1ps
module fir4_fixed_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic out_valid;
  logic [15:0] out_data;

  fir4_fixed uut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
                  .out_valid(out_valid), .out_data(out_data));

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  int hist [4];
  int expq [0:8191];
  real refq [0:8191];
  int head = 0, tail = 0;
  logic vh0 = 1'b0, vh1 = 1'b0;
  int last_out = 0;
  logic done = 1'b0;

  function automatic int model(int a, int b, int c, int d);
    longint p0, p1, p2, p3, s01, s23;
    p0 = (longint'(a) * 4915) >>> 16;
    p1 = (longint'(b) * 1638) >>> 16;
    p2 = (longint'(c) * 14746) >>> 16;
    p3 = (longint'(d) * 11469) >>> 16;
    s01 = (p0 >>> 1) + (p1 >>> 1);
    s23 = (p2 >>> 1) + (p3 >>> 1);
    return int'((s01 >>> 1) + (s23 >>> 1));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic observe();
    int o;
    real e;
    o = $signed(out_data);
    chk(out_valid == vh1, "R6 out_valid latency", int'(out_valid), int'(vh1));
    if (out_valid && head != tail) begin
      chk(o == expq[head], "R1 R2 R3 R4 bit-exact", o, expq[head]);
      e = real'(o) / 4096.0 - refq[head];
      if (e < 0.0) e = -e;
      chk(e < 1.0 / 1024.0, "R5 error bound", o, int'(refq[head] * 4096.0));
      head++;
    end else if (!out_valid) begin
      chk(o == last_out, "R8 hold while idle", o, last_out);
    end
    last_out = o;
  endtask

  task automatic step(input bit v, input int x);
    @(negedge clk);
    observe();
    vh1 = vh0;
    vh0 = v;
    in_valid = v;
    in_data = 16'(x);
    if (v) begin
      hist[3] = hist[2]; hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = x;
      expq[tail] = model(hist[0], hist[1], hist[2], hist[3]);
      refq[tail] = (0.15 * hist[0] + 0.05 * hist[1] + 0.45 * hist[2] + 0.35 * hist[3]) / 32768.0;
      tail++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 reset out_valid", int'(out_valid), 0);
    chk(out_data == 16'h0, "R9 reset out_data", $signed(out_data), 0);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) hist[i] = 0;
    vh0 = 1'b0; vh1 = 1'b0; last_out = 0;
    head = tail;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) hist[i] = 0;
    do_reset();
    // R1: impulse response, each tap weight in turn
    step(1, 32767);
    for (int i = 0; i < 5; i++) step(1, 0);
    step(1, -32768);
    for (int i = 0; i < 5; i++) step(1, 0);
    // R5: full-scale constant inputs
    for (int i = 0; i < 6; i++) step(1, -32768);
    for (int i = 0; i < 6; i++) step(1, 32767);
    // sweep of the input range
    for (int k = 0; k < 256; k++) step(1, -32768 + k * 257);
    // R7: random samples with random idle gaps
    for (int k = 0; k < 3000; k++) begin
      int x;
      x = int'($urandom_range(65535)) - 32768;
      if ($urandom_range(3) == 0) begin
        for (int g = 0; g < int'($urandom_range(4)); g++) step(0, 16'h5a5a);
      end
      step(1, x);
    end
    step(0, 0); step(0, 0); step(0, 0);
    // R9: reset in the middle of a stream clears history
    for (int i = 0; i < 4; i++) step(1, -32768);
    do_reset();
    step(1, 20000);
    step(1, -12345);
    for (int i = 0; i < 4; i++) step(0, 0);
    chk(head == tail, "R6 every strobe produced a result", head, tail);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule